// File: doc/BRIEF.md
# Power-Up and Reset Sequencer

This block brings a measurement device out of power-on, pin reset or software reset in a fixed, timed order. While the qualified supply signal is low, the block holds every output in its reset state. Once the supply is good, the block waits out a hold-off interval with the internal circuitry disabled. It then enables that circuitry and waits out a second, longer start-up interval. Only after both intervals does it open host register access.

The moment access opens, the block raises a reset-complete status flag and pulls its active-low interrupt line low. This completion interrupt has no enable and no mask. Every finished start-up therefore reaches the interrupt pin, whether it followed a power-up, a qualified pin reset or a software reset. The flag and the interrupt stay asserted until the host clears them with a clear strobe.

A hardware reset is accepted only if the external reset pin stays low for a minimum width. Shorter glitches are discarded. Both delays and the minimum width are given in microseconds and converted to clock cycles from a clock-frequency parameter, so a short simulation can use scaled-down values.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `supply_ok` is low, and on the first clock edge after it falls, the outputs take their reset values: `core_en`=0, `host_rdy`=0, `rst_flag`=0, `irq_n`=1.
- R2: After `supply_ok` is sampled high, `core_en` rises exactly HOLD_CYC clock edges later, where HOLD_CYC = CLK_HZ/1e6 × HOLD_US. `host_rdy` stays low during this wait.
- R3: `host_rdy` rises exactly START_CYC clock edges after `core_en` rises, where START_CYC = CLK_HZ/1e6 × START_US. Before that edge, the host strobes `flag_clr` and `sw_rst_req` are ignored.
- R4: On the edge where `host_rdy` rises, `rst_flag` is set to 1 and `irq_n` is driven to 0. No input can suppress this.
- R5: Once set, `rst_flag`=1 and `irq_n`=0 persist until a `flag_clr` pulse is sampled while `host_rdy` is 1. The clock edge that samples the pulse returns them to 0 and 1.
- R6: If `flag_clr` is high on the same edge that completes the sequence, the set wins. The flag is cleared on the following edge only if `flag_clr` is still high.
- R7: If `rst_pin_n` is held low for at least PULSE_CYC = CLK_HZ/1e6 × PULSE_US consecutive samples, the outputs return to their reset values 3+PULSE_CYC edges after the falling edge. After the pin is released, `core_en` rises HOLD_CYC+3 edges after release, and the completion of R3 and R4 follows.
- R8: A low pulse on `rst_pin_n` shorter than PULSE_CYC cycles leaves every output unchanged.
- R9: A `sw_rst_req` pulse sampled while `host_rdy` is 1 returns the outputs to their reset values on that edge. The full hold-off and start-up sequence then runs again and sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_ok | input | 1 | Qualified supply-good level, synchronous to clk; low acts as synchronous reset |
| rst_pin_n | input | 1 | External active-low reset pin, asynchronous |
| sw_rst_req | input | 1 | Host software reset strobe |
| flag_clr | input | 1 | Host strobe that clears the reset-complete flag |
| core_en | output | 1 | Enable for the internal measurement circuitry |
| host_rdy | output | 1 | High when host register access is allowed |
| rst_flag | output | 1 | Non-maskable reset-complete status flag |
| irq_n | output | 1 | Active-low interrupt, low while the flag is set |

## Verification
The assertions assume that `supply_ok`, `sw_rst_req` and `flag_clr` are already synchronous to `clk`. Only `rst_pin_n` may change at any time. The stimulus drives every input on the falling clock edge, which keeps it inside that assumption. Pin pulses are either half or twice the minimum width, never near the qualifying threshold. Host strobes are single-cycle pulses, except one `flag_clr` that is held high on purpose across a completion to exercise the set-over-clear priority.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } seq_phase_e;

  function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                               input int unsigned usec);
    return (clk_hz / 1000000) * usec;
  endfunction

  function automatic int unsigned bits_for(input int unsigned value);
    int unsigned w;
    w = 1;
    while ((value >> w) != 0) w = w + 1;
    return w;
  endfunction

endpackage

// File: rtl/rstpin_qualifier.sv
module rstpin_qualifier #(
  parameter int unsigned MIN_LOW = 50,
  localparam int unsigned LW = pwr_seq_pkg::bits_for(MIN_LOW)
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hw_active
);

  logic          meta_q;
  logic          sync_q;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= pin_n;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (sync_q) begin
      low_cnt <= '0;
    end else if (low_cnt != LW'(MIN_LOW)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign hw_active = (low_cnt == LW'(MIN_LOW));

  // R8
  low_cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= LW'(MIN_LOW));

  // R7
  low_cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> (low_cnt == '0));

endmodule

// File: rtl/seq_delay_counter.sv
module seq_delay_counter #(
  parameter int unsigned W     = 8,
  parameter int unsigned INIT  = 10,
  parameter int unsigned LIMIT = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         at_zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(INIT);
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign at_zero = (cnt == '0);

  // R2
  dec_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(LIMIT));

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm #(
  parameter int unsigned HOLD_CYC  = 200,
  parameter int unsigned START_CYC = 300,
  localparam int unsigned MAXC = (HOLD_CYC > START_CYC) ? HOLD_CYC : START_CYC,
  localparam int unsigned CW   = pwr_seq_pkg::bits_for(MAXC)
) (
  input  logic clk,
  input  logic rst,
  input  logic hw_active,
  input  logic sw_rst_req,
  output logic core_en,
  output logic host_rdy,
  output logic done_evt,
  output logic run_next
);
  import pwr_seq_pkg::*;

  seq_phase_e    phase, phase_nxt;
  logic          force_hold;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          dec;
  logic          zero;

  seq_delay_counter #(
    .W     (CW),
    .INIT  (HOLD_CYC - 1),
    .LIMIT (MAXC - 1)
  ) u_delay (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .dec      (dec),
    .at_zero  (zero)
  );

  always_comb begin
    force_hold = hw_active || (phase == PH_RUN && sw_rst_req);
    phase_nxt  = phase;
    ld         = 1'b0;
    ld_val     = CW'(HOLD_CYC - 1);
    dec        = 1'b0;
    done_evt   = 1'b0;
    if (force_hold) begin
      phase_nxt = PH_HOLD;
      ld        = 1'b1;
    end else begin
      case (phase)
        PH_HOLD: begin
          if (zero) begin
            phase_nxt = PH_START;
            ld        = 1'b1;
            ld_val    = CW'(START_CYC - 1);
          end else begin
            dec = 1'b1;
          end
        end
        PH_START: begin
          if (zero) begin
            phase_nxt = PH_RUN;
            done_evt  = 1'b1;
          end else begin
            dec = 1'b1;
          end
        end
        default: phase_nxt = PH_RUN;
      endcase
    end
  end

  assign run_next = (phase_nxt == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_HOLD;
      core_en  <= 1'b0;
      host_rdy <= 1'b0;
    end else begin
      phase    <= phase_nxt;
      core_en  <= (phase_nxt != PH_HOLD);
      host_rdy <= (phase_nxt == PH_RUN);
    end
  end

  // R3
  rdy_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    host_rdy |-> core_en);

  // R2
  en_before_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_en) |-> !host_rdy);

  // R7
  hw_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    hw_active |=> !core_en);

endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  input  logic run_next,
  input  logic host_rdy,
  output logic flag,
  output logic irq_n
);

  logic flag_nxt;

  always_comb begin
    if (!run_next)      flag_nxt = 1'b0;
    else if (set_evt)   flag_nxt = 1'b1;
    else if (clr_req && host_rdy) flag_nxt = 1'b0;
    else                flag_nxt = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      flag  <= flag_nxt;
      irq_n <= ~flag_nxt;
    end
  end

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req && run_next) |=> flag);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> (flag && !irq_n));

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned HOLD_US  = 26_000,
  parameter int unsigned START_US = 40_000,
  parameter int unsigned PULSE_US = 10
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic rst_pin_n,
  input  logic sw_rst_req,
  input  logic flag_clr,
  output logic core_en,
  output logic host_rdy,
  output logic rst_flag,
  output logic irq_n
);
  import pwr_seq_pkg::*;

  localparam int unsigned HOLD_CYC  = us_to_cycles(CLK_HZ, HOLD_US);
  localparam int unsigned START_CYC = us_to_cycles(CLK_HZ, START_US);
  localparam int unsigned PULSE_CYC = us_to_cycles(CLK_HZ, PULSE_US);

  logic por_rst;
  logic hw_active;
  logic done_evt;
  logic run_next;

  assign por_rst = ~supply_ok;

  rstpin_qualifier #(
    .MIN_LOW (PULSE_CYC)
  ) u_pinq (
    .clk       (clk),
    .rst       (por_rst),
    .pin_n     (rst_pin_n),
    .hw_active (hw_active)
  );

  seq_ctrl_fsm #(
    .HOLD_CYC  (HOLD_CYC),
    .START_CYC (START_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (por_rst),
    .hw_active  (hw_active),
    .sw_rst_req (sw_rst_req),
    .core_en    (core_en),
    .host_rdy   (host_rdy),
    .done_evt   (done_evt),
    .run_next   (run_next)
  );

  rst_status_reg u_stat (
    .clk      (clk),
    .rst      (por_rst),
    .set_evt  (done_evt),
    .clr_req  (flag_clr),
    .run_next (run_next),
    .host_rdy (host_rdy),
    .flag     (rst_flag),
    .irq_n    (irq_n)
  );

  // R4
  flag_with_rdy_chk: assert property (@(posedge clk) disable iff (por_rst)
    $rose(rst_flag) |-> $rose(host_rdy));

  // R4
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (por_rst)
    !irq_n |-> rst_flag);

  // R9
  sw_rst_drop_chk: assert property (@(posedge clk) disable iff (por_rst)
    (sw_rst_req && host_rdy) |=> (!host_rdy && !core_en && irq_n));

endmodule

// File: tb/pwr_rst_seq_tb_top.sv
module pwr_rst_seq_tb_top;

  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned HUS = 4;
  localparam int unsigned SUS = 6;
  localparam int unsigned PUS = 1;
  localparam int H = 200;
  localparam int S = 300;
  localparam int L = 50;

  logic clk = 1'b0;
  logic supply_ok = 1'b0;
  logic rst_pin_n = 1'b1;
  logic sw_rst_req = 1'b0;
  logic flag_clr = 1'b0;
  logic core_en, host_rdy, rst_flag, irq_n;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [3:0] prev_vec;

  int         exp_cyc_q[$];
  logic [3:0] exp_vec_q[$];
  string      exp_tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_rst_seq #(
    .CLK_HZ (CLK_HZ), .HOLD_US (HUS), .START_US (SUS), .PULSE_US (PUS)
  ) dut_i (
    .clk (clk), .supply_ok (supply_ok), .rst_pin_n (rst_pin_n),
    .sw_rst_req (sw_rst_req), .flag_clr (flag_clr),
    .core_en (core_en), .host_rdy (host_rdy), .rst_flag (rst_flag), .irq_n (irq_n)
  );

  function automatic logic [3:0] outv();
    return {core_en, host_rdy, rst_flag, irq_n};
  endfunction

  task automatic expect_at(input int c, input logic [3:0] v, input string tag);
    exp_cyc_q.push_back(c);
    exp_vec_q.push_back(v);
    exp_tag_q.push_back(tag);
  endtask

  task automatic check_now(input logic [3:0] v, input string tag);
    n_cmp++;
    if (outv() !== v) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at cycle %0d", tag, outv(), v, cyc);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every output change must match the head of the queue
  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] v;
      v = outv();
      if (v !== prev_vec) begin
        n_cmp++;
        if (exp_cyc_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected: outputs %b expected %b (no change) at cycle %0d", v, prev_vec, cyc);
        end else begin
          int         ec;
          logic [3:0] ev;
          string      et;
          ec = exp_cyc_q.pop_front();
          ev = exp_vec_q.pop_front();
          et = exp_tag_q.pop_front();
          if (ec != cyc || ev !== v) begin
            n_bad++;
            $display("FAIL %s: outputs %b at cycle %0d expected %b at cycle %0d", et, v, cyc, ev, ec);
          end
        end
        prev_vec = v;
      end
    end
  end

  initial begin
    int n;
    int m;
    idle(5);
    // R1 reset state
    check_now(4'b0001, "R1 reset state");
    prev_vec = outv();
    mon_on = 1'b1;

    // R2 R3 R4 power-up, host strobes during start-up ignored (R3)
    @(negedge clk); supply_ok = 1'b1; n = cyc;
    expect_at(n + H, 4'b1001, "R2 enable after hold-off");
    expect_at(n + H + S, 4'b1110, "R4 completion flag and irq");
    idle(H + 50);
    check_now(4'b1001, "R3 not ready during start-up");
    sw_rst_req = 1'b1; flag_clr = 1'b1;
    @(negedge clk); sw_rst_req = 1'b0; flag_clr = 1'b0;
    idle(S);
    // R5 flag persists
    idle(100);
    check_now(4'b1110, "R5 flag persists");

    // R5 clear
    @(negedge clk); flag_clr = 1'b1; n = cyc;
    expect_at(n + 1, 4'b1101, "R5 clear flag");
    @(negedge clk); flag_clr = 1'b0;
    idle(5);

    // R9 software reset
    @(negedge clk); sw_rst_req = 1'b1; n = cyc;
    expect_at(n + 1, 4'b0001, "R9 sw reset drop");
    expect_at(n + 1 + H, 4'b1001, "R9 re-enable");
    expect_at(n + 1 + H + S, 4'b1110, "R9 completion again");
    @(negedge clk); sw_rst_req = 1'b0;
    idle(H + S + 10);
    @(negedge clk); flag_clr = 1'b1;
    expect_at(cyc + 1, 4'b1101, "R5 clear again");
    @(negedge clk); flag_clr = 1'b0;
    idle(5);

    // R6 set wins over clear held high
    @(negedge clk); sw_rst_req = 1'b1; flag_clr = 1'b1; n = cyc;
    expect_at(n + 1, 4'b0001, "R9 sw reset drop");
    expect_at(n + 1 + H, 4'b1001, "R2 re-enable");
    expect_at(n + 1 + H + S, 4'b1110, "R6 set wins");
    expect_at(n + 2 + H + S, 4'b1101, "R6 clear next edge");
    @(negedge clk); sw_rst_req = 1'b0;
    idle(H + S + 5);
    flag_clr = 1'b0;
    idle(5);

    // R8 short pin pulse ignored
    @(negedge clk); rst_pin_n = 1'b0;
    idle(L / 2);
    rst_pin_n = 1'b1;
    idle(L);
    check_now(4'b1101, "R8 short pulse ignored");

    // R7 qualified pin reset
    @(negedge clk); rst_pin_n = 1'b0; n = cyc;
    m = n + 2 * L;
    expect_at(n + 3 + L, 4'b0001, "R7 pin reset drop");
    expect_at(m + 3 + H, 4'b1001, "R7 re-enable after release");
    expect_at(m + 3 + H + S, 4'b1110, "R7 completion");
    idle(2 * L);
    rst_pin_n = 1'b1;
    idle(H + S + 10);

    // R1 supply drop mid start-up, then full power-up
    @(negedge clk); supply_ok = 1'b0; n = cyc;
    expect_at(n + 1, 4'b0001, "R1 supply drop");
    idle(5);
    @(negedge clk); supply_ok = 1'b1; n = cyc;
    expect_at(n + H, 4'b1001, "R2 enable");
    idle(H + 20);
    @(negedge clk); supply_ok = 1'b0; m = cyc;
    expect_at(m + 1, 4'b0001, "R1 drop during start-up");
    idle(5);
    check_now(4'b0001, "R1 held in reset");
    @(negedge clk); supply_ok = 1'b1; n = cyc;
    expect_at(n + H, 4'b1001, "R2 enable");
    expect_at(n + H + S, 4'b1110, "R4 completion");
    idle(H + S + 10);
    check_now(4'b1110, "R4 final state");

    n_cmp++;
    if (exp_cyc_q.size() != 0) begin
      n_bad++;
      $display("FAIL pending: %0d expected changes missing, expected 0", exp_cyc_q.size());
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule